// File: doc/BRIEF.md
# Write-DMA Control and Status Sequencer

This block is the register front end of a stream-to-memory write DMA. Software writes a control word, a destination address and a transfer length over a plain 32-bit register port. The block turns those writes into a one-cycle start pulse and a level abort request toward a separate burst engine. It keeps the busy, error, aborting, continuous-mode and overflow state that software reads back, and it raises a single-cycle interrupt.

All commands live in the high bits of one control word. Bit 31 starts a transfer. Bit 30 is write-one-to-clear for the error flag, and it may share a write with the start bit. Bit 28 holds continuous mode. Bit 23 is write-one-to-clear for overflow. A control word whose top byte equals 0x26 is an abort key and does nothing else. The engine answers with single-cycle pulses: done when every outstanding write has completed, error, and overflow.

Top module: `wdma_ctrl`

## Requirements
- R1: After reset every flag is clear, no pulse is issued, the address and length read as zero, and the control word reads 0x00090000 (LG_FIFO=9 in bits 19:16, all other bits zero).
- R2: A control write (offset 0x00) whose top byte is not 0x26, with bit 31 set, while idle and with no error left after this write's clear, sets busy (read bit 31) and gives exactly one engStart pulse in the next cycle.
- R3: While the error flag (read bit 30) is set, a start is ignored unless the same word also has bit 30 set. Writing 1 to bit 30 in a non-key control write clears the flag.
- R4: An engErr pulse while busy sets the error flag. An engine error reported at the same edge as a clear wins.
- R5: Every non-key control write loads bit 28 into the continuous flag (read bit 28), which drives engContinuous.
- R6: A control write with top byte 0x26 while busy sets aborting (read bit 29) and raises engAbort, and busy stays set until engDone. The same write while idle changes nothing.
- R7: engDone while busy clears busy and aborting, and irq is high for exactly the next cycle.
- R8: An engOvf pulse sets overflow (read bit 23). Writing 1 to bit 23 in a non-key control write clears it only while idle. A new engOvf wins over a clear.
- R9: When continuous mode is set and overflow goes from 0 to 1, irq is high for the next cycle. There is no such interrupt with continuous mode clear.
- R10: Offset 0x10 holds the destination address and offset 0x18 holds the length. Both drive the engine and read back. Writes to them while busy are ignored, and other offsets read zero. Read bits 27:24, 22:20 and 15:0 of the control word are zero.
- R11: A start request while busy produces no engStart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | ADDR_W | Write byte offset |
| regWrData | input | 32 | Write data |
| regRdAddr | input | ADDR_W | Read byte offset |
| regRdData | output | 32 | Combinational read data |
| engStart | output | 1 | One-cycle start command to the burst engine |
| engAbort | output | 1 | Abort request, held while aborting |
| engContinuous | output | 1 | Continuous-mode enable |
| engDest | output | DEST_W | Destination address |
| engLen | output | LEN_W | Transfer length |
| engDone | input | 1 | Engine pulse: all writes completed |
| engErr | input | 1 | Engine pulse: bus error |
| engOvf | input | 1 | Engine pulse: sample overflow |
| irq | output | 1 | One-cycle interrupt |

## Verification
The bench targets starts that arrive while an error is pending, with and without the clear bit in the same word. A design that checks the stale flag would refuse a start that should run, or accept one that should not. It aims abort keys at an idle block, where a wrong design would hang in an aborting state no engDone can release. It also lands done, error and overflow pulses on the same edge as software writes, so that the wrong priority shows up as a lost flag, a cleared overflow during a transfer, or a missing or doubled interrupt.

// File: rtl/wdma_ctrl_pkg.sv
package wdma_ctrl_pkg;
  localparam int REG_W     = 32;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_DEST  = 'h10;
  localparam int OFS_LEN   = 'h18;
  localparam int B_START   = 31;
  localparam int B_ERR     = 30;
  localparam int B_ABT     = 29;
  localparam int B_CONT    = 28;
  localparam int B_OVF     = 23;
  localparam int LGF_LO    = 16;
  localparam logic [7:0] ABORT_KEY = 8'h26;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ABORT = 2'd2
  } seqState_t;

  typedef struct packed {
    logic wrDest;
    logic wrLen;
  } regStrobe_t;

  typedef struct packed {
    logic busy;
    logic err;
    logic abt;
    logic cont;
    logic ovf;
  } ctrlStat_t;
endpackage

// File: rtl/wdma_ctrl_fsm.sv
module wdma_ctrl_fsm
  import wdma_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              engDone,
  input  logic              engErr,
  input  logic              engOvf,
  output regStrobe_t        strobe,
  output ctrlStat_t         stat,
  output logic              engStart,
  output logic              irq
);
  seqState_t state;
  logic errQ, contQ, ovfQ, startQ, irqQ;
  logic ctrlWr, keyHit, cmdWr, busy;
  logic clrErr, clrOvf, startReq, abortReq, finish, ovfIrq;
  logic unusedData;

  assign unusedData = ^wrData[22:0];

  assign busy     = (state != ST_IDLE);
  assign ctrlWr   = wrEn && (wrAddr == ADDR_W'(OFS_CTRL));
  assign keyHit   = (wrData[31:24] == ABORT_KEY);
  assign cmdWr    = ctrlWr && !keyHit;
  assign clrErr   = cmdWr && wrData[B_ERR];
  assign clrOvf   = cmdWr && wrData[B_OVF] && !busy;
  assign startReq = cmdWr && wrData[B_START] && !busy && !(errQ && !clrErr);
  assign abortReq = ctrlWr && keyHit;
  assign finish   = busy && engDone;
  assign ovfIrq   = engOvf && !ovfQ && contQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errQ   <= 1'b0;
      contQ  <= 1'b0;
      ovfQ   <= 1'b0;
      startQ <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (startReq) state <= ST_RUN;
        ST_RUN:   if (engDone) state <= ST_IDLE;
                  else if (abortReq) state <= ST_ABORT;
        ST_ABORT: if (engDone) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      errQ   <= (errQ && !clrErr) || (busy && engErr);
      if (cmdWr) contQ <= wrData[B_CONT];
      ovfQ   <= (ovfQ && !clrOvf) || engOvf;
      startQ <= startReq;
      irqQ   <= finish || ovfIrq;
    end
  end

  always_comb begin
    strobe.wrDest = wrEn && !busy && (wrAddr == ADDR_W'(OFS_DEST));
    strobe.wrLen  = wrEn && !busy && (wrAddr == ADDR_W'(OFS_LEN));
    stat.busy = busy;
    stat.err  = errQ;
    stat.abt  = (state == ST_ABORT);
    stat.cont = contQ;
    stat.ovf  = ovfQ;
  end

  assign engStart = startQ;
  assign irq      = irqQ;
endmodule

// File: rtl/wdma_ctrl_regs.sv
module wdma_ctrl_regs
  import wdma_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEST_W = 32,
  parameter int LEN_W  = 32,
  parameter int LG_FIFO = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  wrData,
  input  regStrobe_t        strobe,
  input  ctrlStat_t         stat,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [DEST_W-1:0] dest,
  output logic [LEN_W-1:0]  len
);
  localparam logic [3:0] LGF_CODE = 4'(LG_FIFO);

  logic [DEST_W-1:0] destQ;
  logic [LEN_W-1:0]  lenQ;
  logic [REG_W-1:0]  ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ <= '0;
      lenQ  <= '0;
    end else begin
      if (strobe.wrDest) destQ <= DEST_W'(wrData);
      if (strobe.wrLen)  lenQ  <= LEN_W'(wrData);
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[B_START] = stat.busy;
    ctrlWord[B_ERR]   = stat.err;
    ctrlWord[B_ABT]   = stat.abt;
    ctrlWord[B_CONT]  = stat.cont;
    ctrlWord[B_OVF]   = stat.ovf;
    ctrlWord[LGF_LO +: 4] = LGF_CODE;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_W'(OFS_CTRL): rdData = ctrlWord;
      ADDR_W'(OFS_DEST): rdData = REG_W'(destQ);
      ADDR_W'(OFS_LEN):  rdData = REG_W'(lenQ);
      default:           rdData = '0;
    endcase
  end

  assign dest = destQ;
  assign len  = lenQ;
endmodule

// File: rtl/wdma_ctrl.sv
module wdma_ctrl
  import wdma_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DEST_W  = 32,
  parameter int LEN_W   = 32,
  parameter int LG_FIFO = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [31:0]       regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [31:0]       regRdData,
  output logic              engStart,
  output logic              engAbort,
  output logic              engContinuous,
  output logic [DEST_W-1:0] engDest,
  output logic [LEN_W-1:0]  engLen,
  input  logic              engDone,
  input  logic              engErr,
  input  logic              engOvf,
  output logic              irq
);
  regStrobe_t strobe;
  ctrlStat_t  stat;

  wdma_ctrl_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .wrAddr(regWrAddr), .wrData(regWrData),
    .engDone(engDone), .engErr(engErr), .engOvf(engOvf),
    .strobe(strobe), .stat(stat), .engStart(engStart), .irq(irq)
  );

  wdma_ctrl_regs #(
    .ADDR_W(ADDR_W), .DEST_W(DEST_W), .LEN_W(LEN_W), .LG_FIFO(LG_FIFO)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrData(regWrData), .strobe(strobe),
    .stat(stat), .rdAddr(regRdAddr), .rdData(regRdData),
    .dest(engDest), .len(engLen)
  );

  assign engAbort      = stat.abt;
  assign engContinuous = stat.cont;
endmodule

// File: rtl/wdma_ctrl_chk.sv
module wdma_ctrl_chk #(
  parameter int ADDR_W = 5,
  parameter int DEST_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic [31:0]       regWrData,
  input logic              engStart,
  input logic              engAbort,
  input logic              engDone,
  input logic [DEST_W-1:0] engDest,
  input logic              irq,
  input logic              busy,
  input logic              err,
  input logic              ovf
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busy); // R2
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (err && regWrEn && regWrAddr == '0 && !regWrData[30]) |=> !engStart); // R3
  AST_ABORT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |-> busy); // R6
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (busy && engDone) |=> (irq && !busy)); // R7
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && busy) |=> ovf); // R8
  AST_DEST_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(engDest)); // R10
endmodule

bind wdma_ctrl wdma_ctrl_chk #(.ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
  .regWrData(regWrData), .engStart(engStart), .engAbort(engAbort),
  .engDone(engDone), .engDest(engDest), .irq(irq),
  .busy(stat.busy), .err(stat.err), .ovf(stat.ovf)
);

// File: tb/wdma_ctrl_bench.sv
`timescale 1ns/1ps
module wdma_ctrl_bench;
  localparam int AW = 5;
  localparam int LGF = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [AW-1:0] regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [AW-1:0] regRdAddr = '0;
  logic [31:0] regRdData;
  logic engStart, engAbort, engContinuous, irq;
  logic [31:0] engDest, engLen;
  logic engDone = 1'b0, engErr = 1'b0, engOvf = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  bit mBusy, mErr, mAbt, mCont, mOvf;
  logic [31:0] mDest, mLen;

  always #2 clk = ~clk;

  wdma_ctrl #(.ADDR_W(AW), .LG_FIFO(LGF)) u_wdma_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .engStart(engStart), .engAbort(engAbort), .engContinuous(engContinuous),
    .engDest(engDest), .engLen(engLen), .engDone(engDone), .engErr(engErr),
    .engOvf(engOvf), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctrlWord();
    logic [31:0] w = '0;
    w[31] = mBusy; w[30] = mErr; w[29] = mAbt; w[28] = mCont; w[23] = mOvf;
    w[19:16] = 4'(LGF);
    return w;
  endfunction

  task automatic checkAll(input bit eStart, input bit eIrq);
    chk("R2/R11 engStart", 32'(engStart), 32'(eStart));
    chk("R7/R9 irq", 32'(irq), 32'(eIrq));
    chk("R6 engAbort", 32'(engAbort), 32'(mAbt));
    chk("R5 engContinuous", 32'(engContinuous), 32'(mCont));
    chk("R10 engDest", engDest, mDest);
    chk("R10 engLen", engLen, mLen);
    regRdAddr = 5'h00; #0.2;
    chk("R1/R3/R4/R8 ctrl read", regRdData, ctrlWord());
    regRdAddr = 5'h10; #0.2;
    chk("R10 dest read", regRdData, mDest);
    regRdAddr = 5'h18; #0.2;
    chk("R10 len read", regRdData, mLen);
    regRdAddr = 5'h04; #0.2;
    chk("R10 other read", regRdData, 32'h0);
  endtask

  task automatic step(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                      input bit dn, input bit er, input bit ov);
    bit isCtrl, key, cmd, clrE, start, fin, eIrq;
    @(negedge clk);
    regWrEn = wr; regWrAddr = a; regWrData = d;
    engDone = dn; engErr = er; engOvf = ov;
    isCtrl = wr && a == 5'h00;
    key    = d[31:24] == 8'h26;
    cmd    = isCtrl && !key;
    clrE   = cmd && d[30];
    start  = cmd && d[31] && !mBusy && !(mErr && !clrE);
    fin    = mBusy && dn;
    eIrq   = fin || (ov && !mOvf && mCont);
    @(posedge clk);
    #1;
    if (wr && !mBusy && a == 5'h10) mDest = d;
    if (wr && !mBusy && a == 5'h18) mLen = d;
    mOvf = (mOvf && !(cmd && d[23] && !mBusy)) || ov;
    mErr = (mErr && !clrE) || (mBusy && er);
    if (cmd) mCont = d[28];
    if (fin) begin mBusy = 0; mAbt = 0; end
    else if (start) mBusy = 1;
    else if (isCtrl && key && mBusy) mAbt = 1;
    checkAll(start, eIrq);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    mBusy = 0; mErr = 0; mAbt = 0; mCont = 0; mOvf = 0; mDest = '0; mLen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkAll(0, 0);                               // R1 reset state
    // directed corner cases
    step(1, 5'h10, 32'h1000_0040, 0, 0, 0);       // R10 dest
    step(1, 5'h18, 32'h0000_0200, 0, 0, 0);       // R10 len
    step(1, 5'h00, 32'h8000_0000, 0, 0, 0);       // R2 start
    step(1, 5'h10, 32'hDEAD_BEEF, 0, 0, 0);       // R10 ignored while busy
    step(1, 5'h00, 32'h8000_0000, 0, 0, 0);       // R11 start while busy
    step(0, 5'h00, 32'h0, 0, 1, 0);               // R4 error
    step(0, 5'h00, 32'h0, 1, 0, 0);               // R7 done
    step(1, 5'h00, 32'h8000_0000, 0, 0, 0);       // R3 blocked
    step(1, 5'h00, 32'hC000_0000, 0, 0, 0);       // R3 clear+start
    step(1, 5'h00, 32'h2600_0000, 0, 0, 0);       // R6 abort
    step(0, 5'h00, 32'h0, 0, 0, 0);               // R6 stays busy
    step(0, 5'h00, 32'h0, 1, 0, 0);               // R7 abort done
    step(1, 5'h00, 32'h26FF_FFFF, 0, 0, 0);       // R6 ignored idle
    step(1, 5'h00, 32'h1000_0000, 0, 0, 0);       // R5 continuous
    step(0, 5'h00, 32'h0, 0, 0, 1);               // R9 overflow irq
    step(1, 5'h00, 32'h9000_0000, 0, 0, 0);       // start continuous
    step(1, 5'h00, 32'h1080_0000, 0, 0, 0);       // R8 no clear while busy
    step(0, 5'h00, 32'h0, 1, 0, 1);               // R7 + R8 same edge
    step(1, 5'h00, 32'h0080_0000, 0, 0, 0);       // R8 clear idle, R5 cont off
    step(0, 5'h00, 32'h0, 0, 0, 1);               // R9 no irq without cont
    step(1, 5'h00, 32'h0080_0000, 0, 0, 1);       // R8 set wins over clear
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [AW-1:0] a;
      bit wr;
      d = $urandom;
      case ($urandom % 6)
        0: d[31:24] = 8'h80 | (d[31:24] & 8'h50);
        1: d[31:24] = 8'hC0 | (d[31:24] & 8'h10);
        2: d[31:24] = 8'h26;
        3: d[31:24] = d[31:24] & 8'h50;
        default: ;
      endcase
      case ($urandom % 5)
        0: a = 5'h10;
        1: a = 5'h18;
        2: a = 5'h04;
        default: a = 5'h00;
      endcase
      wr = ($urandom % 3) == 0;
      step(wr, a, d, ($urandom % 10) == 0, ($urandom % 25) == 0, ($urandom % 20) == 0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule